// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of a programmable interrupt controller. A host writes a short series of setup bytes over a byte-wide write port made of an address bit, an active-low write strobe and an active-low chip select. All of these are synchronous to the system clock. The block decides which setup word each write carries and stores it. It then drives the decoded configuration to the rest of the controller. That configuration is the input trigger mode, single or cascaded operation, whether a fourth word follows, the vector address bits, and the raw cascade and mode bytes.

The sequence changes with the first word. A first word is any write with the address bit low and data bit 4 set. It is always followed by a vector word, which is a write with the address bit high. A cascade word follows only when the first word's single-mode bit is clear. A mode word follows only when the first word's bit 0 is set. When the last expected word has been written, the ready flag rises and the controller may take interrupts. A new first word restarts the sequence at any time, including after ready.

Top module: `icw_sequencer`

## Requirements
- R1: After synchronous reset `ready` is 0, all stored configuration outputs are 0, and the block waits for a first word.
- R2: A write with `a0`=0 and `din[4]`=1 is taken as the first word in any state, including after ready. It stores `din` and clears `ready`, `cascade_cfg` and `mode_cfg`. The next expected word is the vector word.
- R3: While the vector word is expected, a write with `a0`=1 is stored on `vec_hi`, which carries vector address bits 15..8.
- R4: When first-word bit 1 is 0, the write with `a0`=1 after the vector word is stored on `cascade_cfg`. When bit 1 is 1, no cascade word is expected.
- R5: When first-word bit 0 is 1, the next `a0`=1 write after the vector word and any cascade word is stored on `mode_cfg`. When bit 0 is 0, no mode word is expected. `ready` goes to 1 in the cycle after the last expected word is written.
- R6: `level_mode` equals first-word bit 3, `single_mode` equals bit 1, `icw4_needed` equals bit 0, and `vec_lo` equals bits 7..5.
- R7: Each low period of `wr_n` with `cs_n` low is one write. `din` and `a0` are sampled at the first rising clock edge on which `wr_n` is low. A longer low period, or data that changes during it, has no further effect.
- R8: A low period of `wr_n` while `cs_n` is high changes no output.
- R9: Writes that match no expected word change no output. These are `a0`=0 writes with `din[4]`=0, and `a0`=1 writes once `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| a0 | input | 1 | Address bit that selects the word class |
| din | input | 8 | Write data |
| ready | output | 1 | Initialization complete |
| level_mode | output | 1 | 1 = level-sensitive inputs, 0 = rising-edge inputs |
| single_mode | output | 1 | 1 = single controller, 0 = cascaded |
| icw4_needed | output | 1 | A mode word is part of the sequence |
| vec_lo | output | 3 | Vector address bits 7..5 |
| vec_hi | output | 8 | Vector address bits 15..8 (type bits 7..3 in single-byte vector mode) |
| cascade_cfg | output | 8 | Stored cascade word |
| mode_cfg | output | 8 | Stored mode word |

## Verification
Two functions can act in the same cycle. One is storing the word the sequence expects. The other is the skip decision, which in that same edge chooses the following word, or ready, from the two first-word bits. The bench provokes this for all 256 first-word values. It then checks `ready` and which register received each following `a0`=1 write, against a path computed from bits 1 and 0. A restart landing on a ready block, and a long strobe whose data changes mid-write, are judged by the same register placement.

// File: rtl/icw_pkg.sv
// Package: shared widths, field positions and sequencer state type.
// Assumes one byte-wide host bus; field positions follow the word formats.
package icw_pkg;
    localparam int DATA_W     = 8;
    localparam int TAG_BIT    = 4;  // set in a first word with a0 low
    localparam int IC4_BIT    = 0;
    localparam int SNGL_BIT   = 1;
    localparam int LTIM_BIT   = 3;
    localparam int VLO_MSB    = 7;
    localparam int VLO_LSB    = 5;
    localparam int VLO_W      = VLO_MSB - VLO_LSB + 1;
    localparam int NUM_WORDS  = 4;

    typedef enum logic [2:0] {
        ST_WAIT1 = 3'd0,
        ST_WAIT2 = 3'd1,
        ST_WAIT3 = 3'd2,
        ST_WAIT4 = 3'd3,
        ST_READY = 3'd4
    } seq_state_t;
endpackage

// File: rtl/icw_strobe_edge.sv
// Module: turns the asynchronous-length write strobe into a single-cycle
// write pulse on the first clock edge where wr_n is low with cs_n low.
// Assumes wr_n, cs_n are already synchronous to clk.
module icw_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_pulse
);
    logic wr_q;

    // Remember the previous strobe level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    assign wr_pulse = !cs_n && !wr_n && wr_q;

    // R7
    one_pulse_per_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/icw_step_fsm.sv
// Module: decides which word each write carries and steps through the
// sequence, skipping cascade and mode words as the first word dictates.
// Assumes wr_pulse lasts one cycle per write.
module icw_step_fsm
    import icw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_pulse,
    input  logic                  a0,
    input  logic [DATA_W-1:0]     din,
    input  logic                  single_cfg,
    input  logic                  ic4_cfg,
    output logic [NUM_WORDS-1:0]  load,
    output logic                  ready
);
    seq_state_t state_q, state_d;
    logic       is_first;
    logic       sngl_now, ic4_now;

    assign is_first = wr_pulse && !a0 && din[TAG_BIT];
    // Skip decisions after the vector word use the stored first word.
    assign sngl_now = single_cfg;
    assign ic4_now  = ic4_cfg;

    // Select the store enable and the next state for this cycle.
    always_comb begin
        state_d = state_q;
        load    = '0;
        if (is_first) begin
            load[0] = 1'b1;
            state_d = ST_WAIT2;
        end else if (wr_pulse && a0) begin
            unique case (state_q)
                ST_WAIT2: begin
                    load[1] = 1'b1;
                    if (!sngl_now)    state_d = ST_WAIT3;
                    else if (ic4_now) state_d = ST_WAIT4;
                    else              state_d = ST_READY;
                end
                ST_WAIT3: begin
                    load[2] = 1'b1;
                    state_d = ic4_now ? ST_WAIT4 : ST_READY;
                end
                ST_WAIT4: begin
                    load[3] = 1'b1;
                    state_d = ST_READY;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // Hold the current position in the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT1;
        else        state_q <= state_d;
    end

    assign ready = (state_q == ST_READY);

    // R2
    restart_to_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !a0 && din[TAG_BIT]) |=> (state_q == ST_WAIT2 && !ready));
    // R5
    ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(wr_pulse));
    // R4
    skip_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && a0 && !din[TAG_BIT] && state_q == ST_WAIT2 && single_cfg && !ic4_cfg)
        |=> ready);
endmodule

// File: rtl/icw_word_regs.sv
// Module: stores the setup words and decodes the configuration fields.
// Assumes at most one load enable per cycle; a first-word load clears
// the cascade and mode words.
module icw_word_regs
    import icw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_WORDS-1:0]  load,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     w1,
    output logic [DATA_W-1:0]     w2,
    output logic [DATA_W-1:0]     w3,
    output logic [DATA_W-1:0]     w4
);
    logic [DATA_W-1:0] word_q [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        // Capture word g on its enable; a first word clears later words.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (load[g])
                word_q[g] <= din;
            else if (g >= 2 && load[0])
                word_q[g] <= '0;
        end
    end

    assign w1 = word_q[0];
    assign w2 = word_q[1];
    assign w3 = word_q[2];
    assign w4 = word_q[3];

    // R9
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));
    // R2
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> (w3 == '0 && w4 == '0));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load == '0) |=> ($stable(w1) && $stable(w2) && $stable(w3) && $stable(w4)));
endmodule

// File: rtl/icw_sequencer.sv
// Module: top of the initialization front end. Detects writes, steps the
// word sequence and presents the decoded configuration.
// Assumes all bus inputs are synchronous to clk.
module icw_sequencer
    import icw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              a0,
    input  logic [7:0]        din,
    output logic              ready,
    output logic              level_mode,
    output logic              single_mode,
    output logic              icw4_needed,
    output logic [2:0]        vec_lo,
    output logic [7:0]        vec_hi,
    output logic [7:0]        cascade_cfg,
    output logic [7:0]        mode_cfg
);
    logic                 wr_pulse;
    logic [NUM_WORDS-1:0] load;
    logic [DATA_W-1:0]    w1, w2, w3, w4;

    icw_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse)
    );

    icw_step_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pulse   (wr_pulse),
        .a0         (a0),
        .din        (din),
        .single_cfg (w1[SNGL_BIT]),
        .ic4_cfg    (w1[IC4_BIT]),
        .load       (load),
        .ready      (ready)
    );

    icw_word_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (din),
        .w1    (w1),
        .w2    (w2),
        .w3    (w3),
        .w4    (w4)
    );

    assign level_mode  = w1[LTIM_BIT];
    assign single_mode = w1[SNGL_BIT];
    assign icw4_needed = w1[IC4_BIT];
    assign vec_lo      = w1[VLO_MSB:VLO_LSB];
    assign vec_hi      = w2;
    assign cascade_cfg = w3;
    assign mode_cfg    = w4;

    // R3
    vec_follows_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load[1] |-> !ready);
endmodule

// File: tb/test_icw_sequencer.sv
module test_icw_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       a0 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       ready, level_mode, single_mode, icw4_needed;
    logic [2:0] vec_lo;
    logic [7:0] vec_hi, cascade_cfg, mode_cfg;

    int checks = 0;
    int errors = 0;

    icw_sequencer i_icw_sequencer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .din(din),
        .ready(ready), .level_mode(level_mode), .single_mode(single_mode),
        .icw4_needed(icw4_needed), .vec_lo(vec_lo), .vec_hi(vec_hi),
        .cascade_cfg(cascade_cfg), .mode_cfg(mode_cfg)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write: strobe low for 'hold' clock edges; optional data change after the first.
    task automatic wr(input logic a, input logic [7:0] d, input int hold,
                      input logic chg, input logic [7:0] d2);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = a; din = d;
        @(posedge clk);
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            if (chg) din = d2;
            @(posedge clk);
        end
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic rdy, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [7:0] e3, input logic [7:0] e4);
        chk({req, " ready"}, ready, rdy);
        chk({req, " level"}, level_mode, e1[3]);
        chk({req, " single"}, single_mode, e1[1]);
        chk({req, " ic4"}, icw4_needed, e1[0]);
        chk({req, " vec_lo"}, vec_lo, e1[7:5]);
        chk({req, " vec_hi"}, vec_hi, e2);
        chk({req, " cascade"}, cascade_cfg, e3);
        chk({req, " mode"}, mode_cfg, e4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] e1, e2, e3, e4;
        logic       rdy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1", 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);

        // R8 strobe with chip select inactive
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; a0 = 1'b0; din = 8'h13;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk_all("R8", 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);

        // Sweep every first-word value (tag bit forced)
        e2 = 8'h00;
        for (int i = 0; i < 256; i++) begin
            e1 = 8'(i) | 8'h10;
            e3 = 8'h00; e4 = 8'h00;
            wr(1'b0, e1, 1 + (i % 3), 1'b0, 8'h00);
            chk_all("R2 R6", 1'b0, e1, e2, e3, e4);
            // R9 a0 low without tag bit is ignored during init
            wr(1'b0, e1 & 8'hEF, 1, 1'b0, 8'h00);
            chk_all("R9 untagged", 1'b0, e1, e2, e3, e4);
            // R3 vector word; R7 long strobe with mid-write change
            e2 = 8'(i) ^ 8'hA5;
            wr(1'b1, e2, 1 + (i % 4), 1'b1, ~e2);
            rdy = e1[1] && !e1[0];
            chk_all("R3 R7", rdy, e1, e2, e3, e4);
            if (!rdy) begin
                if (!e1[1]) begin
                    e3 = ~8'(i);
                    wr(1'b1, e3, 2, 1'b1, 8'h5A);
                    rdy = !e1[0];
                    chk_all("R4", rdy, e1, e2, e3, e4);
                end
                if (!rdy) begin
                    e4 = 8'(i + 7);
                    wr(1'b1, e4, 1, 1'b0, 8'h00);
                    rdy = 1'b1;
                    chk_all("R5", rdy, e1, e2, e3, e4);
                end
            end
            // R9 extra a0 high write after ready
            wr(1'b1, 8'h3C, 1, 1'b0, 8'h00);
            chk_all("R9 after ready", 1'b1, e1, e2, e3, e4);
        end

        // R2 restart from ready clears cascade and mode
        wr(1'b0, 8'h10, 1, 1'b0, 8'h00);
        chk_all("R2 restart", 1'b0, 8'h10, e2, 8'h00, 8'h00);
        wr(1'b1, 8'hC8, 1, 1'b0, 8'h00);
        chk_all("R4 cascade expected", 1'b0, 8'h10, 8'hC8, 8'h00, 8'h00);
        wr(1'b1, 8'h04, 1, 1'b0, 8'h00);
        chk_all("R5 no mode word", 1'b1, 8'h10, 8'hC8, 8'h04, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule